// File: doc/BRIEF.md
# Flash Read Timing Calibration Engine

This block sits beside a serial flash controller and searches for the fastest serial clock divider, together with an input sampling delay, that still returns correct data. It first reads a reference block at the slowest safe setting and stores it in an internal RAM. It then checks that the stored data has enough variety to be a meaningful test pattern. If it does, the engine tries each permitted divider from slowest to fastest. For each divider it steps through a fixed list of delay codes and re-reads the whole block several times at each code, comparing every word against the reference.

The engine drives a simple read-request port and presents the divider under trial (`div_o`) and the timing register (`timing_o`) to the controller. The timing register holds one 4-bit delay field per divider. When calibration ends, `result_div_o` and `div_o` give the fastest divider that passed, or zero to keep the slow setting. A read error from the controller aborts the run at once.

Top module: `calib_read_tuner`

## Requirements
- R1: After reset, busy_o, done_o, err_o, rd_req_o, div_o, result_div_o and timing_o are all zero. A start_i pulse while idle raises busy_o on the next cycle and loads timing_o from timing_init_i.
- R2: The reference capture reads word addresses 0 to BLOCK_WORDS-1 in ascending order with div_o = 0 (slow setting) and stores them before any trial read.
- R3: A word is varied when it is neither all zeros nor all ones. If fewer than MIN_VARIED reference words are varied, the run finishes after the capture with result 0, with timing_o equal to timing_init_i and with no further reads.
- R4: Dividers are tried in the order NUM_DIV down to 1. A divider d is skipped, and no read is issued with div_o = d, when base_freq_i >= max_freq_i * d, so equality also skips.
- R5: Candidate index i (0..NUM_CAND-1) uses delay code {i even, i/2}: bit 3 is set for even i and bits 2:0 hold i/2. The code for divider d is written to timing_o bits [4(d-1)+3 : 4(d-1)].
- R6: A candidate passes only when READ_REPS back-to-back reads of the whole block all match the reference. A mismatch on any word in any repetition fails the candidate.
- R7: Scanning of a divider stops at the third consecutive passing candidate, and that divider's field is set to the code of the index one below it. A failing candidate resets the run count.
- R8: A divider with no run of three passes is failed, and its field keeps the code of the last candidate tried (index 11, code 0x5).
- R9: Timing bits outside the field of the divider under trial never change during a run.
- R10: At completion, result_div_o is the smallest divider that passed, or 0 if none passed, and div_o then shows the same value.
- R11: rd_err_i on an outstanding read ends the run on the next edge, with busy_o low, done_o high, err_o high and result 0.
- R12: done_o is a single-cycle pulse with busy_o low, and at most one read is outstanding at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration run (ignored while busy) |
| base_freq_i | input | FREQ_W | Undivided controller clock frequency |
| max_freq_i | input | FREQ_W | Highest serial clock allowed for reads |
| timing_init_i | input | TIMING_W | Timing register value loaded at start |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | clog2(BLOCK_WORDS) | Word address of the request |
| rd_valid_i | input | 1 | Read data returned |
| rd_err_i | input | 1 | Read failed |
| rd_data_i | input | DATA_W | Returned data word |
| div_o | output | clog2(NUM_DIV+1) | Divider in use: 0 is slow, otherwise the trial or result divider |
| timing_o | output | TIMING_W | Per-divider delay code register |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (pulse) |
| err_o | output | 1 | Last run aborted on read error |
| result_div_o | output | clog2(NUM_DIV+1) | Chosen divider, 0 if none |

## Verification
The assertions assume that the controller answers only a read that is outstanding, with exactly one rd_valid_i or rd_err_i pulse per request. They also assume that base_freq_i and max_freq_i stay constant for the whole run. The bench's responder serves one request at a time after a random latency of one or two cycles, and it changes the frequency inputs only while the engine is idle. The responder corrupts data according to per-divider masks of good delay codes and can inject a late failure on the last repetition or an error on a chosen read.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REF_REQ,
    ST_REF_WAIT,
    ST_VAR_CHK,
    ST_DIV_SEL,
    ST_CAND_SET,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CAND_END
  } cal_state_e;

  // bit 3: extra input delay off for even indices; bits 2:0: cycle delay
  function automatic logic [3:0] cand_code(input logic [3:0] idx);
    return {~idx[0], idx[3:1]};
  endfunction

endpackage

// File: rtl/calib_ref_ram.sv
module calib_ref_ram #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/calib_variety_cnt.sv
module calib_variety_cnt #(
  parameter int unsigned WORDS      = 128,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MIN_VARIED = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              enough_o
);

  localparam int unsigned CNT_W = $clog2(WORDS + 1);

  logic [CNT_W-1:0] count_q;
  logic             varied;

  assign varied = (data_i != '0) && (data_i != '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 count_q <= '0;
    else if (clr_i)              count_q <= '0;
    else if (sample_i && varied) count_q <= count_q + 1'b1;
  end

  assign enough_o = 32'(count_q) >= MIN_VARIED;

endmodule

// File: rtl/calib_run_tracker.sv
module calib_run_tracker #(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic eval_i,
  input  logic pass_i,
  output logic hit_o
);

  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = eval_i && pass_i && (cnt_q == CW'(RUN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (eval_i)  cnt_q <= (pass_i && !hit_o) ? cnt_q + 1'b1 : '0;
  end

endmodule

// File: rtl/calib_timing_reg.sv
module calib_timing_reg #(
  parameter int unsigned NUM_DIV  = 5,
  parameter int unsigned TIMING_W = 32,
  localparam int unsigned DIVW    = $clog2(NUM_DIV + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [TIMING_W-1:0] load_val_i,
  input  logic                wr_i,
  input  logic [DIVW-1:0]     wr_div_i,
  input  logic [3:0]          wr_code_i,
  output logic [TIMING_W-1:0] timing_o
);

  localparam int unsigned FIELD_BITS = NUM_DIV * 4;

  for (genvar f = 0; f < NUM_DIV; f++) begin : g_field
    logic [3:0] field_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      field_q <= '0;
      else if (load_i)                                  field_q <= load_val_i[f*4 +: 4];
      else if (wr_i && (wr_div_i == DIVW'(f + 1)))      field_q <= wr_code_i;
    end
    assign timing_o[f*4 +: 4] = field_q;
  end

  if (TIMING_W > FIELD_BITS) begin : g_rest
    logic [TIMING_W-FIELD_BITS-1:0] rest_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rest_q <= '0;
      else if (load_i) rest_q <= load_val_i[TIMING_W-1:FIELD_BITS];
    end
    assign timing_o[TIMING_W-1:FIELD_BITS] = rest_q;
  end

endmodule

// File: rtl/calib_read_tuner.sv
module calib_read_tuner
  import calib_pkg::*;
#(
  parameter int unsigned BLOCK_WORDS = 128,
  parameter int unsigned MIN_VARIED  = 64,
  parameter int unsigned READ_REPS   = 10,
  parameter int unsigned NUM_DIV     = 5,
  parameter int unsigned NUM_CAND    = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FREQ_W      = 32,
  parameter int unsigned TIMING_W    = 32,
  localparam int unsigned AW         = $clog2(BLOCK_WORDS),
  localparam int unsigned DIVW       = $clog2(NUM_DIV + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [FREQ_W-1:0]   base_freq_i,
  input  logic [FREQ_W-1:0]   max_freq_i,
  input  logic [TIMING_W-1:0] timing_init_i,
  output logic                rd_req_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic                rd_valid_i,
  input  logic                rd_err_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic [DIVW-1:0]     div_o,
  output logic [TIMING_W-1:0] timing_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [DIVW-1:0]     result_div_o
);

  localparam int unsigned CW = $clog2(NUM_CAND);
  localparam int unsigned RW = (READ_REPS > 1) ? $clog2(READ_REPS) : 1;
  localparam int unsigned PW = FREQ_W + DIVW;
  localparam logic [AW-1:0] LAST_WORD = AW'(BLOCK_WORDS - 1);
  localparam logic [RW-1:0] LAST_REP  = RW'(READ_REPS - 1);
  localparam logic [CW-1:0] LAST_CAND = CW'(NUM_CAND - 1);
  localparam int unsigned RUN_LEN = 3;

  cal_state_e        state_q;
  logic [AW-1:0]     word_q;
  logic [RW-1:0]     rep_q;
  logic [CW-1:0]     cand_q;
  logic [DIVW-1:0]   div_q, best_q, result_q;
  logic              pass_q, done_q, err_q;

  logic              ram_we, var_clr, var_enough;
  logic              tr_eval, tr_clr, run_hit;
  logic              tm_wr;
  logic [3:0]        tm_code;
  logic [CW-1:0]     cand_prev;
  logic [DATA_W-1:0] ref_word;
  logic              data_match, div_skip;
  logic [PW-1:0]     clk_limit;

  // ---------------- datapath helpers ----------------
  assign rd_req_o  = (state_q == ST_REF_REQ) || (state_q == ST_RD_REQ);
  assign rd_addr_o = word_q;
  assign ram_we    = (state_q == ST_REF_WAIT) && rd_valid_i && !rd_err_i;
  assign var_clr   = (state_q == ST_IDLE) && start_i;
  assign tr_eval   = (state_q == ST_CAND_END);
  assign tr_clr    = (state_q == ST_DIV_SEL);
  assign cand_prev = cand_q - 1'b1;
  assign tm_wr     = (state_q == ST_CAND_SET) || (tr_eval && run_hit);
  assign tm_code   = (state_q == ST_CAND_SET) ? cand_code(4'(cand_q)) : cand_code(4'(cand_prev));
  assign data_match = (rd_data_i == ref_word);

  // clock = base/d is at or above max  <=>  base >= max*d
  assign clk_limit = {{DIVW{1'b0}}, max_freq_i} * {{FREQ_W{1'b0}}, div_q};
  assign div_skip  = {{DIVW{1'b0}}, base_freq_i} >= clk_limit;

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign result_div_o = result_q;
  assign div_o        = busy_o ? div_q : result_q;

  // ---------------- submodules ----------------
  calib_ref_ram #(
    .WORDS  (BLOCK_WORDS),
    .DATA_W (DATA_W)
  ) i_ref_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (word_q),
    .wdata_i (rd_data_i),
    .raddr_i (word_q),
    .rdata_o (ref_word)
  );

  calib_variety_cnt #(
    .WORDS      (BLOCK_WORDS),
    .DATA_W     (DATA_W),
    .MIN_VARIED (MIN_VARIED)
  ) i_variety (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (var_clr),
    .sample_i (ram_we),
    .data_i   (rd_data_i),
    .enough_o (var_enough)
  );

  calib_run_tracker #(
    .RUN_LEN (RUN_LEN)
  ) i_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tr_clr),
    .eval_i (tr_eval),
    .pass_i (pass_q),
    .hit_o  (run_hit)
  );

  calib_timing_reg #(
    .NUM_DIV  (NUM_DIV),
    .TIMING_W (TIMING_W)
  ) i_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (var_clr),
    .load_val_i (timing_init_i),
    .wr_i       (tm_wr),
    .wr_div_i   (div_q),
    .wr_code_i  (tm_code),
    .timing_o   (timing_o)
  );

  // ---------------- control ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      rep_q    <= '0;
      cand_q   <= '0;
      div_q    <= '0;
      best_q   <= '0;
      result_q <= '0;
      pass_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_REF_REQ;
            word_q   <= '0;
            div_q    <= '0;
            best_q   <= '0;
            result_q <= '0;
            err_q    <= 1'b0;
          end
        end
        ST_REF_REQ: state_q <= ST_REF_WAIT;
        ST_REF_WAIT: begin
          if (rd_err_i) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            err_q    <= 1'b1;
            result_q <= '0;
          end else if (rd_valid_i) begin
            if (word_q == LAST_WORD) begin
              state_q <= ST_VAR_CHK;
            end else begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_REF_REQ;
            end
          end
        end
        ST_VAR_CHK: begin
          if (var_enough) begin
            div_q   <= DIVW'(NUM_DIV);
            state_q <= ST_DIV_SEL;
          end else begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            result_q <= '0;
          end
        end
        ST_DIV_SEL: begin
          if (div_q == '0) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            result_q <= best_q;
          end else if (div_skip) begin
            div_q <= div_q - 1'b1;
          end else begin
            cand_q  <= '0;
            state_q <= ST_CAND_SET;
          end
        end
        ST_CAND_SET: begin
          word_q  <= '0;
          rep_q   <= '0;
          state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: state_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (rd_err_i) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            err_q    <= 1'b1;
            result_q <= '0;
          end else if (rd_valid_i) begin
            if (!data_match) begin
              pass_q  <= 1'b0;
              state_q <= ST_CAND_END;
            end else if (word_q == LAST_WORD) begin
              if (rep_q == LAST_REP) begin
                pass_q  <= 1'b1;
                state_q <= ST_CAND_END;
              end else begin
                rep_q   <= rep_q + 1'b1;
                word_q  <= '0;
                state_q <= ST_RD_REQ;
              end
            end else begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_CAND_END: begin
          if (run_hit) begin
            best_q  <= div_q;
            div_q   <= div_q - 1'b1;
            state_q <= ST_DIV_SEL;
          end else if (cand_q == LAST_CAND) begin
            div_q   <= div_q - 1'b1;
            state_q <= ST_DIV_SEL;
          end else begin
            cand_q  <= cand_q + 1'b1;
            state_q <= ST_CAND_SET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/calib_read_tuner_chk.sv
module calib_read_tuner_chk #(
  parameter int unsigned NUM_DIV  = 5,
  parameter int unsigned FREQ_W   = 32,
  parameter int unsigned TIMING_W = 32,
  localparam int unsigned DIVW    = $clog2(NUM_DIV + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rd_req_o,
  input logic                rd_valid_i,
  input logic                rd_err_i,
  input logic [FREQ_W-1:0]   base_freq_i,
  input logic [FREQ_W-1:0]   max_freq_i,
  input logic [DIVW-1:0]     div_o,
  input logic [TIMING_W-1:0] timing_o,
  input logic                busy_o,
  input logic                done_o,
  input logic                err_o,
  input logic [DIVW-1:0]     result_div_o
);

  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pending_q <= 1'b0;
    else if (rd_req_o)              pending_q <= 1'b1;
    else if (rd_valid_i || rd_err_i) pending_q <= 1'b0;
  end

  function automatic logic [TIMING_W-1:0] fmask(input logic [DIVW-1:0] d);
    logic [TIMING_W-1:0] m;
    m = '0;
    if (d != '0) m = {{(TIMING_W-4){1'b0}}, 4'hF} << (4 * (int'(d) - 1));
    return m;
  endfunction

  assert_req_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);

  assert_no_skipped_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && div_o != '0) |->
      ({{DIVW{1'b0}}, base_freq_i} < ({{DIVW{1'b0}}, max_freq_i} * {{FREQ_W{1'b0}}, div_o})));

  assert_other_fields_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (((timing_o ^ $past(timing_o)) & ~fmask($past(div_o))) == '0));

  assert_result_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_div_o <= DIVW'(NUM_DIV)));

  assert_div_shows_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (div_o == result_div_o));

  assert_err_abort_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && rd_err_i && busy_o) |=> (!busy_o && done_o && err_o && result_div_o == '0));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_single_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pending_q);

endmodule

bind calib_read_tuner calib_read_tuner_chk #(
  .NUM_DIV  (NUM_DIV),
  .FREQ_W   (FREQ_W),
  .TIMING_W (TIMING_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_req_o     (rd_req_o),
  .rd_valid_i   (rd_valid_i),
  .rd_err_i     (rd_err_i),
  .base_freq_i  (base_freq_i),
  .max_freq_i   (max_freq_i),
  .div_o        (div_o),
  .timing_o     (timing_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .result_div_o (result_div_o)
);

// File: tb/test_calib_read_tuner.sv
`timescale 1ns/1ps
module test_calib_read_tuner;

  localparam int WORDS = 8;
  localparam int MINV  = 4;
  localparam int REPS  = 10;
  localparam int NDIV  = 5;
  localparam int NCAND = 12;
  localparam int AW    = $clog2(WORDS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_f = 32'd100;
  logic [31:0] max_f = 32'd1000;
  logic [31:0] t_init = '0;
  logic        rd_valid = 1'b0;
  logic        rd_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [2:0]    div;
  logic [31:0]   timing;
  logic          busy, done, err;
  logic [2:0]    result;

  always #2.5 clk = ~clk;

  calib_read_tuner #(
    .BLOCK_WORDS (WORDS),
    .MIN_VARIED  (MINV),
    .READ_REPS   (REPS),
    .NUM_DIV     (NDIV),
    .NUM_CAND    (NCAND)
  ) i_calib_read_tuner (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .base_freq_i   (base_f),
    .max_freq_i    (max_f),
    .timing_init_i (t_init),
    .rd_req_o      (rd_req),
    .rd_addr_o     (rd_addr),
    .rd_valid_i    (rd_valid),
    .rd_err_i      (rd_err),
    .rd_data_i     (rd_data),
    .div_o         (div),
    .timing_o      (timing),
    .busy_o        (busy),
    .done_o        (done),
    .err_o         (err),
    .result_div_o  (result)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] golden [WORDS];
  logic [11:0] pmask [1:NDIV];
  logic [11:0] lmask [1:NDIV];
  int          err_at = -1;
  int          read_cnt = 0;
  int          seq [8];
  int          seq_n = 0;
  int          last_dv = 0;
  bit          ref_bad = 0;
  int          rep = 0;
  logic [34:0] last_key = '1;
  int          exp_seq [8];
  int          exp_n = 0;
  int          exp_res = 0;
  logic [31:0] exp_tm = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int i);
    return {((i % 2) == 0) ? 1'b1 : 1'b0, 3'(i / 2)};
  endfunction

  function automatic logic [31:0] model_word(input int a, input int dv, input logic [31:0] tm);
    logic [3:0] c;
    int idx;
    bit ok;
    if (dv == 0) return golden[a];
    c = tm[(dv-1)*4 +: 4];
    idx = 2 * int'(c[2:0]) + (c[3] ? 0 : 1);
    ok = (c[2:0] <= 3'd5) && pmask[dv][idx] && !(lmask[dv][idx] && rep == REPS - 1);
    return ok ? golden[a] : (golden[a] ^ 32'h0000_0100);
  endfunction

  task automatic serve();
    forever begin
      @(negedge clk);
      while (rd_req) begin
        int a;
        int dv;
        int lat;
        logic [31:0] tm;
        a = int'(rd_addr);
        dv = int'(div);
        tm = timing;
        read_cnt++;
        if (read_cnt <= WORDS && (a != read_cnt - 1 || dv != 0)) ref_bad = 1;
        if (dv != 0 && dv != last_dv && seq_n < 8) begin
          seq[seq_n] = dv;
          seq_n++;
        end
        last_dv = dv;
        if (a == 0) begin
          if ({3'(dv), tm} == last_key) rep++;
          else begin
            rep = 0;
            last_key = {3'(dv), tm};
          end
        end
        lat = 1 + int'($urandom % 2);
        repeat (lat) @(negedge clk);
        if (read_cnt == err_at) rd_err = 1'b1;
        else begin
          rd_valid = 1'b1;
          rd_data = model_word(a, dv, tm);
        end
        @(negedge clk);
        rd_valid = 1'b0;
        rd_err = 1'b0;
      end
    end
  endtask

  task automatic compute_expected(input logic [31:0] b, input logic [31:0] m, input logic [31:0] init);
    int varied;
    varied = 0;
    for (int w = 0; w < WORDS; w++)
      if (golden[w] != 32'h0 && golden[w] != 32'hFFFF_FFFF) varied++;
    exp_res = 0;
    exp_tm = init;
    exp_n = 0;
    if (varied < MINV) return;
    for (int d = NDIV; d >= 1; d--) begin
      int run;
      bit found;
      if ({3'b0, b} >= {3'b0, m} * 35'(d)) continue;
      exp_seq[exp_n] = d;
      exp_n++;
      run = 0;
      found = 0;
      for (int i = 0; i < NCAND; i++) begin
        if (pmask[d][i] && !lmask[d][i]) run++;
        else run = 0;
        if (run == 3) begin
          exp_tm[(d-1)*4 +: 4] = exp_code(i - 1);
          exp_res = d;
          found = 1;
          break;
        end
      end
      if (!found) exp_tm[(d-1)*4 +: 4] = exp_code(NCAND - 1);
    end
  endtask

  task automatic fill_golden();
    for (int w = 0; w < WORDS; w++) begin
      golden[w] = $urandom;
      if (golden[w] == 32'h0 || golden[w] == 32'hFFFF_FFFF) golden[w] = 32'h1234_5678;
    end
  endtask

  task automatic set_masks(input logic [11:0] p, input logic [11:0] l);
    for (int d = 1; d <= NDIV; d++) begin
      pmask[d] = p;
      lmask[d] = l;
    end
  endtask

  task automatic run_case(input string tag, input logic [31:0] b, input logic [31:0] m,
                          input logic [31:0] init, input bit expect_err);
    bit busy_seen;
    base_f = b;
    max_f = m;
    t_init = init;
    read_cnt = 0;
    seq_n = 0;
    last_dv = 0;
    ref_bad = 0;
    rep = 0;
    last_key = '1;
    compute_expected(b, m, init);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    chk(busy_seen, {"R1 busy after start ", tag}, 64'(busy), 64'd1);
    while (!done) @(negedge clk);
    chk(!busy, {"R12 busy low at done ", tag}, 64'(busy), 64'd0);
    if (expect_err) begin
      chk(err == 1'b1, {"R11 err flag ", tag}, 64'(err), 64'd1);
      chk(result == 3'd0, {"R11 result on abort ", tag}, 64'(result), 64'd0);
      chk(read_cnt == err_at, {"R11 no read after error ", tag}, 64'(read_cnt), 64'(err_at));
    end else begin
      chk(err == 1'b0, {"R11 err clear ", tag}, 64'(err), 64'd0);
      chk(int'(result) == exp_res, {"R10 result ", tag}, 64'(result), 64'(exp_res));
      chk(div == result, {"R10 div shows result ", tag}, 64'(div), 64'(result));
      chk(timing == exp_tm, {"R5 R7 R8 R9 timing ", tag}, 64'(timing), 64'(exp_tm));
      chk(!ref_bad, {"R2 reference order ", tag}, 64'(ref_bad), 64'd0);
      begin
        bit same;
        same = (seq_n == exp_n);
        for (int k = 0; k < exp_n && k < 8; k++) if (seq[k] != exp_seq[k]) same = 0;
        chk(same, {"R4 divider order ", tag}, 64'(seq_n), 64'(exp_n));
      end
    end
    @(negedge clk);
    chk(!done, {"R12 done one cycle ", tag}, 64'(done), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    fork
      serve();
    join_none

    // reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_req, "R1 reset flags", {busy, done, err, rd_req}, 64'd0);
    chk(timing == 32'h0 && div == 3'd0 && result == 3'd0, "R1 reset values", 64'(timing), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && timing == 32'h0, "R1 idle after reset", 64'(timing), 64'd0);

    // all good: each divider selects index 1, fastest wins; upper bits kept
    fill_golden();
    set_masks(12'hFFF, 12'h000);
    run_case("all_pass", 32'd100, 32'd1000, 32'h5A5F_FFFF, 0);

    // uniform reference: 3 varied words < MIN_VARIED
    for (int w = 0; w < WORDS; w++) golden[w] = (w % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF;
    golden[1] = 32'h0000_00F0;
    golden[4] = 32'h8000_0001;
    golden[6] = 32'h1111_2222;
    run_case("uniform", 32'd100, 32'd1000, 32'hC0DE_1234, 0);
    chk(read_cnt == WORDS, "R3 only reference read", 64'(read_cnt), 64'(WORDS));

    // run reset by a failure: 0,1 pass, 2 fails, 3,4,5 pass -> index 4 on divider 5
    fill_golden();
    set_masks(12'h000, 12'h000);
    pmask[5] = 12'b0000_0011_1011;
    run_case("run_reset", 32'd100, 32'd1000, 32'h0, 0);
    chk(timing[19:16] == 4'hA, "R7 code of index 4", 64'(timing[19:16]), 64'hA);
    chk(timing[3:0] == 4'h5, "R8 failed divider keeps last code", 64'(timing[3:0]), 64'h5);

    // late failure on the last repetition of index 1 on divider 4
    set_masks(12'h000, 12'h000);
    pmask[4] = 12'b0000_0001_1111;
    lmask[4] = 12'b0000_0000_0010;
    run_case("late_fail", 32'd100, 32'd1000, 32'h0, 0);
    chk(timing[15:12] == 4'h1, "R6 last repetition checked", 64'(timing[15:12]), 64'h1);

    // frequency limit: base 120, max 40 -> 3 skipped on equality, 2 and 1 skipped
    set_masks(12'hFFF, 12'h000);
    run_case("freq_skip", 32'd120, 32'd40, 32'hFFFF_FFFF, 0);
    chk(result == 3'd4, "R4 equality skips divider 3", 64'(result), 64'd4);

    // nothing passes anywhere
    set_masks(12'h000, 12'h000);
    run_case("none_pass", 32'd100, 32'd1000, 32'h0, 0);
    chk(timing[19:0] == 20'h55555, "R8 all fields at last code", 64'(timing[19:0]), 64'h55555);

    // read errors: during reference and during calibration
    set_masks(12'hFFF, 12'h000);
    err_at = 3;
    run_case("err_ref", 32'd100, 32'd1000, 32'h0, 1);
    err_at = 40;
    run_case("err_cal", 32'd100, 32'd1000, 32'h0, 1);
    err_at = -1;
    run_case("after_err", 32'd100, 32'd1000, 32'h0, 0);

    // constrained random runs
    for (int n = 0; n < 3; n++) begin
      fill_golden();
      for (int d = 1; d <= NDIV; d++) begin
        pmask[d] = 12'($urandom) | 12'($urandom);
        lmask[d] = 12'($urandom) & 12'($urandom) & 12'($urandom);
      end
      run_case($sformatf("rand%0d", n), 32'd100, 32'd18 + ($urandom % 20), $urandom, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule